// File: doc/BRIEF.md
# Key-Locked Configuration Register Unit

This block holds a small set of configuration registers on a 32-bit register bus. The bus has a word offset, a write strobe with write data, and a read strobe with read data. Every configuration register is write-protected in one of two ways.

The first group of registers each has its own lock register. Writing that lock's key opens a short write window that hardware closes again after a fixed number of cycles. Software has to place the protected write inside that window. The second group shares one global pair of kick registers. Both kick registers must hold their keys before any register in that group accepts a write, and writing anything else to a kick register restores the protection.

On top of either scheme, each register has a parameter mask of write-once bits. A write can set these bits but can never clear them. Reads are never gated.

Top module: `keylock_cfg`

## Requirements
- R1: A single-lock register at word offset i (0 to 3) takes a write only while lock i is open. A write while the lock is closed leaves the register unchanged.
- R2: Writing key 0xA5C3_0001 + i to lock i at offset 4 + i opens it. It then stays open for exactly RELOCK_CYC cycles (default 4), starting with the cycle after the key write, and closes without further action.
- R3: Writing any value other than its key to a lock, zero included, leaves it closed or closes it at once.
- R4: Reading a lock register returns 1 when it is open and 0 when it is closed. Reading kick register A (offset 10) or B (offset 11) returns 1 when it holds its key and 0 otherwise.
- R5: The kick-protected registers at offsets 8 and 9 take a write only while kick A holds 0x83E7_0B13 and kick B holds 0x95A4_F1E0. One matching key on its own is not enough.
- R6: Writing any non-key value to either kick register brings the kick protection back from the next cycle.
- R7: Write-once bits can go from 0 to 1 but never back to 0, even inside an open window. The other bits take the written value. The default masks are 0x0000_000F for offset 0, 0xF000_0000 for offset 1, 0x0000_FF00 for offset 2, none for offsets 3 and 8, and 0x0000_0001 for offset 9.
- R8: Reads are never locked and have a latency of one cycle. Read data updates at the clock edge that samples the read strobe and holds otherwise. Unmapped offsets (12 to 15) read 0, and writes to them have no effect.
- R9: Reset clears every configuration register to 0, closes every lock and clears both kick registers. Reset asserts asynchronously and is released synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_re |

## Verification
A window counter that is off by one shows up at the bus as a protected write that lands, or fails to land, in the 4th or 5th cycle after the key write. The boundary vectors place a write in each of those two cycles. A kick match flag stuck at 1 lets a write through with only one key present, and the read-back one cycle later shows it. A corrupted write-once merge either clears a sticky bit or blocks an ordinary bit, which the read of a zero write right after a set exposes. A stale read register shows at the next read strobe, or as data that changes while no read strobe is given.

// File: rtl/keylock_cfg_pkg.sv
package keylock_cfg_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CFG_LK,
    RG_LOCK,
    RG_CFG_KK,
    RG_KICK_A,
    RG_KICK_B
  } region_e;

  // Word map: locked cfg, then their locks, then kicked cfg, then kick A/B.
  function automatic region_e region_of(input int idx, input int nl, input int nk);
    if (idx < nl)                 return RG_CFG_LK;
    else if (idx < 2*nl)          return RG_LOCK;
    else if (idx < 2*nl + nk)     return RG_CFG_KK;
    else if (idx == 2*nl + nk)    return RG_KICK_A;
    else if (idx == 2*nl + nk + 1) return RG_KICK_B;
    else                          return RG_NONE;
  endfunction

  function automatic int sub_of(input int idx, input int nl, input int nk);
    if (idx < nl)             return idx;
    else if (idx < 2*nl)      return idx - nl;
    else if (idx < 2*nl + nk) return idx - 2*nl;
    else                      return 0;
  endfunction

endpackage

// File: rtl/keylock_lock_gate.sv
module keylock_lock_gate #(
  parameter int              DATA_W     = 32,
  parameter int              RELOCK_CYC = 4,
  parameter logic [DATA_W-1:0] KEY      = 32'hA5C3_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_data,
  output logic              open_o
);
  localparam int              WIN_W    = $clog2(RELOCK_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(RELOCK_CYC);

  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             key_hit;

  assign key_hit = key_we && (key_data == KEY);
  assign cnt_en  = key_we || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (key_we) begin
      cnt_d = key_hit ? WIN_LOAD : '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - WIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign open_o = (cnt_q != '0);

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_we && (key_data == KEY) |=> open_o);

  // R3
  stay_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_o && !(key_we && (key_data == KEY)) |=> !open_o);

  // R3
  wrong_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_we && (key_data != KEY) |=> !open_o);

  // R2
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIN_LOAD);

endmodule

// File: rtl/keylock_kick_pair.sv
module keylock_kick_pair #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_A  = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY_B  = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        kick_we,
  input  logic [DATA_W-1:0] kick_data,
  output logic [1:0]        match_o,
  output logic              open_o
);
  localparam logic [1:0][DATA_W-1:0] KEYS = {KEY_B, KEY_A};

  logic [1:0] match_q, match_d;

  for (genvar k = 0; k < 2; k++) begin : g_kick
    always_comb begin
      match_d[k] = match_q[k];
      if (kick_we[k]) begin
        match_d[k] = (kick_data == KEYS[k]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        match_q[k] <= 1'b0;
      end else if (kick_we[k]) begin
        match_q[k] <= match_d[k];
      end
    end

    // R6
    kick_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_we[k] && (kick_data != KEYS[k]) |=> !open_o);
  end

  assign match_o = match_q;
  assign open_o  = &match_q;

endmodule

// File: rtl/keylock_wo_reg.sv
module keylock_wo_reg #(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] WO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (we) begin
      q_d = (wdata & ~WO_MASK) | ((q_q | wdata) & WO_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (we) begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

  // R7
  wo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~q_q) & $past(q_q) & WO_MASK) == '0);

  // R1
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q_q));

endmodule

// File: rtl/keylock_cfg.sv
module keylock_cfg
  import keylock_cfg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int N_LOCKED   = 4,
  parameter int N_KICKED   = 2,
  parameter int RELOCK_CYC = 4,
  parameter logic [DATA_W-1:0] LOCK_KEY_BASE = 32'hA5C3_0001,
  parameter logic [DATA_W-1:0] KICK_KEY_A    = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KICK_KEY_B    = 32'h95A4_F1E0,
  parameter logic [N_LOCKED-1:0][DATA_W-1:0] LK_WO_MASK =
    {32'h0000_0000, 32'h0000_FF00, 32'hF000_0000, 32'h0000_000F},
  parameter logic [N_KICKED-1:0][DATA_W-1:0] KK_WO_MASK =
    {32'h0000_0001, 32'h0000_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int MAP_WORDS = 2*N_LOCKED + N_KICKED + 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  // decode
  region_e rgn;
  int      idx;
  int      sub;

  always_comb begin
    idx = int'(bus_addr);
    rgn = region_of(idx, N_LOCKED, N_KICKED);
    sub = sub_of(idx, N_LOCKED, N_KICKED);
  end

  // single-lock registers
  logic [N_LOCKED-1:0] lk_open;
  logic [N_LOCKED-1:0] lk_key_we;
  logic [N_LOCKED-1:0] lk_cfg_we;
  logic [DATA_W-1:0]   lk_q [N_LOCKED];

  for (genvar i = 0; i < N_LOCKED; i++) begin : g_lk
    assign lk_key_we[i] = bus_we && (rgn == RG_LOCK)   && (sub == i);
    assign lk_cfg_we[i] = bus_we && (rgn == RG_CFG_LK) && (sub == i) && lk_open[i];

    keylock_lock_gate #(
      .DATA_W     (DATA_W),
      .RELOCK_CYC (RELOCK_CYC),
      .KEY        (LOCK_KEY_BASE + DATA_W'(i))
    ) u_gate (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .key_we   (lk_key_we[i]),
      .key_data (bus_wdata),
      .open_o   (lk_open[i])
    );

    keylock_wo_reg #(
      .DATA_W  (DATA_W),
      .WO_MASK (LK_WO_MASK[i])
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_i_n),
      .we    (lk_cfg_we[i]),
      .wdata (bus_wdata),
      .q     (lk_q[i])
    );

    // R1
    lk_gate_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
      bus_we && (rgn == RG_CFG_LK) && (sub == i) && !lk_open[i] |=> $stable(lk_q[i]));
  end

  // kick-protected registers
  logic [1:0]          kick_we;
  logic [1:0]          kick_match;
  logic                kk_open;
  logic [N_KICKED-1:0] kk_cfg_we;
  logic [DATA_W-1:0]   kk_q [N_KICKED];

  assign kick_we[0] = bus_we && (rgn == RG_KICK_A);
  assign kick_we[1] = bus_we && (rgn == RG_KICK_B);

  keylock_kick_pair #(
    .DATA_W (DATA_W),
    .KEY_A  (KICK_KEY_A),
    .KEY_B  (KICK_KEY_B)
  ) u_kick (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .kick_we   (kick_we),
    .kick_data (bus_wdata),
    .match_o   (kick_match),
    .open_o    (kk_open)
  );

  for (genvar j = 0; j < N_KICKED; j++) begin : g_kk
    assign kk_cfg_we[j] = bus_we && (rgn == RG_CFG_KK) && (sub == j) && kk_open;

    keylock_wo_reg #(
      .DATA_W  (DATA_W),
      .WO_MASK (KK_WO_MASK[j])
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_i_n),
      .we    (kk_cfg_we[j]),
      .wdata (bus_wdata),
      .q     (kk_q[j])
    );

    // R5
    kk_gate_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
      bus_we && (rgn == RG_CFG_KK) && (sub == j) && (kick_match != 2'b11) |=> $stable(kk_q[j]));
  end

  // read path: one cycle latency, held between strobes
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    unique case (rgn)
      RG_CFG_LK: for (int i = 0; i < N_LOCKED; i++) if (sub == i) rd_d = lk_q[i];
      RG_LOCK:   for (int i = 0; i < N_LOCKED; i++) if (sub == i) rd_d = {{(DATA_W-1){1'b0}}, lk_open[i]};
      RG_CFG_KK: for (int j = 0; j < N_KICKED; j++) if (sub == j) rd_d = kk_q[j];
      RG_KICK_A: rd_d = {{(DATA_W-1){1'b0}}, kick_match[0]};
      RG_KICK_B: rd_d = {{(DATA_W-1){1'b0}}, kick_match[1]};
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_q <= '0;
    end else if (bus_re) begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata = rd_q;

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_re |=> $stable(bus_rdata));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_re && (int'(bus_addr) >= MAP_WORDS) |=> (bus_rdata == '0));

endmodule

// File: tb/keylock_cfg_bench.sv
`timescale 1ns/1ps
module keylock_cfg_bench;

  localparam logic [1:0] OP_W = 2'd0;
  localparam logic [1:0] OP_R = 2'd1;
  localparam logic [1:0] OP_I = 2'd2;
  localparam int NV = 61;

  // {req[3:0], op[1:0], addr[3:0], data[31:0], expect[31:0]}
  localparam logic [73:0] VEC [NV] = '{
    {4'd9, OP_R, 4'd0,  32'h0,          32'h0},          // R9 cfg0 reset
    {4'd9, OP_R, 4'd4,  32'h0,          32'h0},          // R9 lock0 closed
    {4'd1, OP_W, 4'd0,  32'hFFFF_FFFF,  32'h0},
    {4'd1, OP_R, 4'd0,  32'h0,          32'h0},          // R1 locked write ignored
    {4'd2, OP_W, 4'd4,  32'hA5C3_0001,  32'h0},
    {4'd2, OP_W, 4'd0,  32'h1234_5678,  32'h0},
    {4'd2, OP_R, 4'd0,  32'h0,          32'h1234_5678},  // R2 write in window
    {4'd7, OP_W, 4'd0,  32'h0,          32'h0},
    {4'd7, OP_R, 4'd0,  32'h0,          32'h0000_0008},  // R7 sticky low nibble
    {4'd2, OP_R, 4'd4,  32'h0,          32'h0},          // R2 relocked
    {4'd4, OP_W, 4'd5,  32'hA5C3_0002,  32'h0},
    {4'd4, OP_R, 4'd5,  32'h0,          32'h1},          // R4 open reads 1
    {4'd7, OP_W, 4'd1,  32'hF000_00AA,  32'h0},
    {4'd7, OP_R, 4'd1,  32'h0,          32'hF000_00AA},  // R7
    {4'd7, OP_W, 4'd1,  32'h0,          32'h0},
    {4'd7, OP_R, 4'd1,  32'h0,          32'hF000_0000},  // R7 top nibble sticky
    {4'd3, OP_W, 4'd6,  32'hDEAD_BEEF,  32'h0},
    {4'd3, OP_W, 4'd2,  32'h0000_0055,  32'h0},
    {4'd3, OP_R, 4'd2,  32'h0,          32'h0},          // R3 wrong key
    {4'd3, OP_R, 4'd6,  32'h0,          32'h0},          // R3 lock reads 0
    {4'd3, OP_W, 4'd6,  32'hA5C3_0003,  32'h0},
    {4'd3, OP_W, 4'd6,  32'h0,          32'h0},
    {4'd3, OP_W, 4'd2,  32'h0000_FF00,  32'h0},
    {4'd3, OP_R, 4'd2,  32'h0,          32'h0},          // R3 zero closes
    {4'd2, OP_W, 4'd7,  32'hA5C3_0004,  32'h0},
    {4'd2, OP_I, 4'd0,  32'h0,          32'h0},
    {4'd2, OP_I, 4'd0,  32'h0,          32'h0},
    {4'd2, OP_I, 4'd0,  32'h0,          32'h0},
    {4'd2, OP_W, 4'd3,  32'h0000_0077,  32'h0},
    {4'd2, OP_R, 4'd3,  32'h0,          32'h0000_0077},  // R2 last window cycle
    {4'd2, OP_W, 4'd7,  32'hA5C3_0004,  32'h0},
    {4'd2, OP_I, 4'd0,  32'h0,          32'h0},
    {4'd2, OP_I, 4'd0,  32'h0,          32'h0},
    {4'd2, OP_I, 4'd0,  32'h0,          32'h0},
    {4'd2, OP_I, 4'd0,  32'h0,          32'h0},
    {4'd2, OP_W, 4'd3,  32'h0000_0099,  32'h0},
    {4'd2, OP_R, 4'd3,  32'h0,          32'h0000_0077},  // R2 one cycle late
    {4'd5, OP_W, 4'd8,  32'h0000_ABCD,  32'h0},
    {4'd5, OP_R, 4'd8,  32'h0,          32'h0},          // R5 no keys
    {4'd5, OP_W, 4'd10, 32'h83E7_0B13,  32'h0},
    {4'd5, OP_W, 4'd8,  32'h0000_0011,  32'h0},
    {4'd5, OP_R, 4'd8,  32'h0,          32'h0},          // R5 one key only
    {4'd5, OP_W, 4'd11, 32'h95A4_F1E0,  32'h0},
    {4'd4, OP_R, 4'd10, 32'h0,          32'h1},          // R4 kick A
    {4'd4, OP_R, 4'd11, 32'h0,          32'h1},          // R4 kick B
    {4'd5, OP_W, 4'd8,  32'h0000_ABCD,  32'h0},
    {4'd5, OP_R, 4'd8,  32'h0,          32'h0000_ABCD},  // R5 both keys
    {4'd7, OP_W, 4'd9,  32'h0000_0003,  32'h0},
    {4'd7, OP_W, 4'd9,  32'h0,          32'h0},
    {4'd7, OP_R, 4'd9,  32'h0,          32'h0000_0001},  // R7 kicked sticky bit
    {4'd6, OP_W, 4'd10, 32'h0,          32'h0},
    {4'd6, OP_W, 4'd8,  32'h0,          32'h0},
    {4'd6, OP_R, 4'd8,  32'h0,          32'h0000_ABCD},  // R6 zero kick A
    {4'd6, OP_R, 4'd10, 32'h0,          32'h0},          // R6 kick A reads 0
    {4'd6, OP_W, 4'd10, 32'h83E7_0B13,  32'h0},
    {4'd6, OP_W, 4'd11, 32'h1234_5678,  32'h0},
    {4'd6, OP_W, 4'd8,  32'h0000_0005,  32'h0},
    {4'd6, OP_R, 4'd8,  32'h0,          32'h0000_ABCD},  // R6 wrong kick B
    {4'd8, OP_W, 4'd12, 32'hFFFF_FFFF,  32'h0},
    {4'd8, OP_R, 4'd12, 32'h0,          32'h0},          // R8 unmapped
    {4'd8, OP_R, 4'd15, 32'h0,          32'h0}           // R8 unmapped
  };

  logic        clk;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;

  int checks;
  int errors;

  keylock_cfg u_keylock_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %08h expected %08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input int req);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    apply_reset();

    for (int v = 0; v < NV; v++) begin
      logic [73:0] e;
      e = VEC[v];
      case (e[69:68])
        OP_W:    bus_write(e[67:64], e[63:32]);
        OP_R:    bus_read(e[67:64], e[31:0], int'(e[73:70]));
        default: @(negedge clk);
      endcase
    end

    // R8: read data holds while no read strobe is given
    bus_read(4'd8, 32'h0000_ABCD, 8);
    bus_addr = 4'd0;
    repeat (2) @(negedge clk);
    check(8, bus_rdata, 32'h0000_ABCD);

    // R9: reset in the middle of an open window
    bus_write(4'd4, 32'hA5C3_0001);
    apply_reset();
    bus_read(4'd4, 32'h0, 9);
    bus_read(4'd0, 32'h0, 9);
    bus_read(4'd8, 32'h0, 9);
    bus_read(4'd10, 32'h0, 9);
    bus_read(4'd9, 32'h0, 9);

    // R1 after reset: the lock still has to be opened
    bus_write(4'd0, 32'h0000_00F0);
    bus_read(4'd0, 32'h0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule